// File: doc/BRIEF.md
# Dual Scanline Interrupt Generator

This block watches the position reported by a raster timing generator and raises three interrupt pulses from it: two scanline interrupts whose lines software programs, and a retrace interrupt at the top of every field. The timing generator supplies the line number, the dot (pixel clock) position within the line, the parity of the current field and the number of lines in a field. Interrupt aggregation, masking and acknowledgement are done elsewhere.

Software programs both scanline targets with one 32-bit register write. A target value N stands for a pair of lines. The interrupt fires on line 2N while an even field is scanned and on line 2N+1 while an odd field is scanned. If the target lies at or before the current line, the next hit therefore falls in the next field, using that field's parity. A resolved line that does not exist in the field never fires. New target values and a new field length apply from the next line start onward, so there is nothing stale to cancel.

A line start is the first cycle in which the dot position is zero. Every interrupt is a one-cycle pulse that is registered once, so it is high in the cycle after the line-start cycle.

Top module: `scan_irq_gen`

## Requirements
- R1: A write through `cfg_we`/`cfg_wdata` stores only bits 25:16 (target 1) and bits 9:0 (target 2); every other bit is stored as zero. `cfg_rdata` returns the stored value from the cycle after the write.
- R2: `irq_scan1` pulses when a line start occurs on line 2×T1+F, where T1 is target 1 and F is `ras_field_odd` (0 = even field, 1 = odd field).
- R3: `irq_scan2` behaves in the same way for target 2 (bits 9:0).
- R4: A scanline interrupt whose resolved line 2×T+F is greater than `tot_lines_m1` never fires, even if the line input reaches that value. A resolved line equal to `tot_lines_m1` does fire.
- R5: `irq_retrace` pulses at the line start of line 0 in every field, whatever the field parity.
- R6: A line start is a cycle with `ras_dot` equal to 0 whose previous cycle had `ras_dot` not equal to 0. The previous dot value counts as non-zero right after reset. If the dot stays at 0, each interrupt fires at most once.
- R7: Each pulse is high for exactly one cycle, in the cycle that follows the line-start cycle.
- R8: A register write takes effect from the next cycle. A line start in the same cycle as the write is compared against the old targets, and later line starts against the new ones.
- R9: While `rst_n` is low, all three interrupts are low and the register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the target register |
| cfg_wdata | input | DATA_W | Write data; bits 25:16 are target 1, bits 9:0 are target 2 |
| cfg_rdata | output | DATA_W | Stored (masked) register value |
| tot_lines_m1 | input | LINE_W | Lines per field minus one |
| ras_line | input | LINE_W | Current line from the timing generator |
| ras_dot | input | DOT_W | Current dot position within the line |
| ras_field_odd | input | 1 | Field parity: 1 = odd field, 0 = even field |
| irq_scan1 | output | 1 | Scanline interrupt pulse for target 1 |
| irq_scan2 | output | 1 | Scanline interrupt pulse for target 2 |
| irq_retrace | output | 1 | Retrace interrupt pulse at line 0 |

## Verification
Every interrupt pulse is due exactly one cycle after the cycle whose inputs form the line start. The readback of a write is due one cycle after the strobe. The bench drives each cycle's inputs at the falling edge and computes the expected pulses and readback from those inputs at that moment. It compares them at the next falling edge, after the single register stage has updated. Directed cases place a register write on the same cycle as a line start, hold the dot at zero for several cycles and put the resolved line exactly at and just beyond the field length. These cases confirm that the one-cycle offset holds at those boundaries too.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  // Register layout of the two targets
  localparam int unsigned TGT_W   = 10;
  localparam int unsigned NUM_TGT = 2;

  // Bit position of each target inside the register (target 1 high half)
  function automatic int unsigned tgt_lsb(input int unsigned idx);
    return (idx == 0) ? 16 : 0;
  endfunction

  function automatic logic [31:0] field_ones();
    return (32'd1 << TGT_W) - 32'd1;
  endfunction

  localparam logic [31:0] VPOS_MASK = (field_ones() << tgt_lsb(0)) | (field_ones() << tgt_lsb(1));

  // How a channel turns its target into a line number
  typedef enum logic {
    PM_FIXED = 1'b0,   // line = 2*target
    PM_FIELD = 1'b1    // line = 2*target + field parity
  } parity_mode_e;

endpackage

// File: rtl/scan_irq_vposreg.sv
module scan_irq_vposreg
  import scan_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output logic [DATA_W-1:0]               reg_q,
  output logic [NUM_TGT-1:0][TGT_W-1:0]   tgt
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(VPOS_MASK);

  function automatic logic [DATA_W-1:0] keep_fields(input logic [DATA_W-1:0] v);
    return v & KEEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (cfg_we) reg_q <= keep_fields(cfg_wdata);
  end

  for (genvar gi = 0; gi < NUM_TGT; gi++) begin : g_field
    assign tgt[gi] = reg_q[tgt_lsb(gi) +: TGT_W];
  end

endmodule

// File: rtl/scan_irq_linestart.sv
module scan_irq_linestart #(
  parameter int unsigned DOT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DOT_W-1:0] dot,
  output logic             line_start
);

  logic [DOT_W-1:0] dot_q;

  // Reset value is non-zero so the first zero dot after reset counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dot_q <= '1;
    else        dot_q <= dot;
  end

  assign line_start = (dot == '0) && (dot_q != '0);

endmodule

// File: rtl/scan_irq_chan.sv
module scan_irq_chan
  import scan_irq_pkg::*;
#(
  parameter int unsigned  LINE_W = 10,
  parameter int unsigned  T_W    = 10,
  parameter parity_mode_e MODE   = PM_FIELD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] tot_m1,
  input  logic [T_W-1:0]    target,
  output logic              hit,
  output logic              irq_q
);

  localparam int unsigned RES_W  = LINE_W + 1;
  localparam logic        PAR_EN = (MODE == PM_FIELD);

  // Target N maps to line 2N (+1 in an odd field when parity is used)
  function automatic logic [RES_W-1:0] resolve(input logic [T_W-1:0] t, input logic f);
    return RES_W'({t, f & PAR_EN});
  endfunction

  // A resolved line exists only if it is within the field
  function automatic logic live(input logic [RES_W-1:0] r, input logic [LINE_W-1:0] m1);
    return r <= RES_W'(m1);
  endfunction

  logic [RES_W-1:0] res_line;
  logic             res_live;

  assign res_line = resolve(target, field_odd);
  assign res_live = live(res_line, tot_m1);
  assign hit      = line_start && res_live && (RES_W'(line) == res_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit;
  end

endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
  import scan_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DOT_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [LINE_W-1:0] tot_lines_m1,
  input  logic [LINE_W-1:0] ras_line,
  input  logic [DOT_W-1:0]  ras_dot,
  input  logic              ras_field_odd,
  output logic              irq_scan1,
  output logic              irq_scan2,
  output logic              irq_retrace
);

  logic [NUM_TGT-1:0][TGT_W-1:0] tgt;
  logic [NUM_TGT-1:0]            scan_hit;
  logic [NUM_TGT-1:0]            scan_irq;
  logic                          line_start;
  logic                          retrace_hit;

  scan_irq_vposreg #(.DATA_W(DATA_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .reg_q     (cfg_rdata),
    .tgt       (tgt)
  );

  scan_irq_linestart #(.DOT_W(DOT_W)) u_ls (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot        (ras_dot),
    .line_start (line_start)
  );

  for (genvar gi = 0; gi < NUM_TGT; gi++) begin : g_scan
    scan_irq_chan #(.LINE_W(LINE_W), .T_W(TGT_W), .MODE(PM_FIELD)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .line       (ras_line),
      .field_odd  (ras_field_odd),
      .tot_m1     (tot_lines_m1),
      .target     (tgt[gi]),
      .hit        (scan_hit[gi]),
      .irq_q      (scan_irq[gi])
    );
  end

  // Retrace: fixed target 0 without parity offset, i.e. line 0 of every field
  scan_irq_chan #(.LINE_W(LINE_W), .T_W(1), .MODE(PM_FIXED)) u_retrace (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .line       (ras_line),
    .field_odd  (ras_field_odd),
    .tot_m1     (tot_lines_m1),
    .target     (1'b0),
    .hit        (retrace_hit),
    .irq_q      (irq_retrace)
  );

  assign irq_scan1 = scan_irq[0];
  assign irq_scan2 = scan_irq[1];

endmodule

// File: rtl/scan_irq_gen_chk.sv
module scan_irq_gen_chk
  import scan_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DOT_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [LINE_W-1:0] tot_lines_m1,
  input logic [LINE_W-1:0] ras_line,
  input logic [DOT_W-1:0]  ras_dot,
  input logic              ras_field_odd,
  input logic              line_start,
  input logic              irq_scan1,
  input logic              irq_scan2,
  input logic              irq_retrace
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(VPOS_MASK);

  AST_RDATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP) == '0); // R1

  AST_SCAN1_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_scan1 |-> ($past(ras_dot) == '0) && ($past(ras_line[0]) == $past(ras_field_odd))); // R2

  AST_SCAN2_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_scan2 |-> ($past(ras_dot) == '0) && ($past(ras_line[0]) == $past(ras_field_odd))); // R3

  AST_SCAN_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_scan1 || irq_scan2) |-> ($past(ras_line) <= $past(tot_lines_m1))); // R4

  AST_RETRACE_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_retrace |-> ($past(ras_line) == '0) && $past(line_start)); // R5

  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start); // R6

  AST_SCAN1_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_scan1 |=> !irq_scan1); // R7

  AST_RETRACE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_retrace |=> !irq_retrace); // R7

endmodule

bind scan_irq_gen scan_irq_gen_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rdata     (cfg_rdata),
  .tot_lines_m1  (tot_lines_m1),
  .ras_line      (ras_line),
  .ras_dot       (ras_dot),
  .ras_field_odd (ras_field_odd),
  .line_start    (line_start),
  .irq_scan1     (irq_scan1),
  .irq_scan2     (irq_scan2),
  .irq_retrace   (irq_retrace)
);

// File: tb/scan_irq_gen_tb.sv
`timescale 1ns/1ps
module scan_irq_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [9:0]  tot_lines_m1 = 10'd15;
  logic [9:0]  ras_line = 10'd5;
  logic [9:0]  ras_dot = 10'd1;
  logic        ras_field_odd = 1'b0;
  logic        irq_scan1, irq_scan2, irq_retrace;

  always #4 clk = ~clk;

  scan_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tot_lines_m1(tot_lines_m1), .ras_line(ras_line), .ras_dot(ras_dot),
    .ras_field_odd(ras_field_odd), .irq_scan1(irq_scan1), .irq_scan2(irq_scan2),
    .irq_retrace(irq_retrace)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench model state
  logic [31:0] m_reg = '0;
  logic [9:0]  m_t1 = '0, m_t2 = '0;
  logic [9:0]  m_prev_dot = 10'd1;
  logic        e_s1 = 0, e_s2 = 0, e_rt = 0;

  // Raster generator state
  logic [9:0]  r_line = '0, r_dot = '0;
  logic        r_field = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Fires when line is odd/even as the field says and its upper bits equal the target
  function automatic logic exp_scan(input logic [9:0] t, input logic [9:0] ln, input logic fo,
                                    input logic [9:0] tm1, input logic ls);
    return ls && (ln[0] == fo) && ({1'b0, ln[9:1]} == t) && (ln <= tm1);
  endfunction

  task automatic step(input logic we, input logic [31:0] wd, input logic [9:0] ln,
                      input logic [9:0] dt, input logic fo, input logic [9:0] tm1,
                      input string tag);
    logic ls;
    @(negedge clk);
    chk({tag, " R2 R7 scan1"}, {31'd0, irq_scan1}, {31'd0, e_s1});
    chk({tag, " R3 scan2"},    {31'd0, irq_scan2}, {31'd0, e_s2});
    chk({tag, " R5 retrace"},  {31'd0, irq_retrace}, {31'd0, e_rt});
    chk({tag, " R1 readback"}, cfg_rdata, m_reg);
    cfg_we = we; cfg_wdata = wd; ras_line = ln; ras_dot = dt;
    ras_field_odd = fo; tot_lines_m1 = tm1;
    ls   = (dt == 10'd0) && (m_prev_dot != 10'd0);
    e_s1 = exp_scan(m_t1, ln, fo, tm1, ls);
    e_s2 = exp_scan(m_t2, ln, fo, tm1, ls);
    e_rt = ls && (ln == 10'd0);
    m_prev_dot = dt;
    if (we) begin
      m_reg = {6'd0, wd[25:16], 6'd0, wd[9:0]};
      m_t1  = wd[25:16];
      m_t2  = wd[9:0];
    end
  endtask

  task automatic run_raster(input int cycles, input logic [9:0] tm1, input int dlen,
                            input bit ilace, input int wr_pm, input string tag);
    logic        we;
    logic [31:0] wd;
    r_line = '0; r_dot = 10'd1;
    for (int c = 0; c < cycles; c++) begin
      we = ($urandom_range(0, 999) < wr_pm);
      wd = $urandom;
      wd[25:16] = 10'($urandom_range(0, 25));
      wd[9:0]   = 10'($urandom_range(0, 25));
      step(we, wd, r_line, r_dot, r_field, tm1, tag);
      if (r_dot >= 10'(dlen - 1)) begin
        r_dot = '0;
        if (r_line >= tm1) begin
          r_line = '0;
          if (ilace) r_field = ~r_field;
        end else r_line = r_line + 10'd1;
      end else r_dot = r_dot + 10'd1;
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 reset scan1",   {31'd0, irq_scan1}, 32'd0);
    chk("R9 reset scan2",   {31'd0, irq_scan2}, 32'd0);
    chk("R9 reset retrace", {31'd0, irq_retrace}, 32'd0);
    chk("R9 reset reg",     cfg_rdata, 32'd0);
    rst_n = 1'b1;

    // R1: masking of all-ones write
    step(1, 32'hFFFF_FFFF, 10'd3, 10'd2, 0, 10'd15, "R1");
    step(0, 32'h0,         10'd3, 10'd3, 0, 10'd15, "R1");
    chk("R1 mask all ones", cfg_rdata, 32'h03FF_03FF);

    // R6: dot held at zero gives one pulse; t1=2 -> line 4 even, t2=3 -> line 7 odd
    step(1, 32'h0002_0003, 10'd4, 10'd1, 0, 10'd15, "R6");
    step(0, 0, 10'd4, 10'd0, 0, 10'd15, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 10'd4, 10'd0, 0, 10'd15, "R6");
    step(0, 0, 10'd7, 10'd1, 1, 10'd15, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 10'd7, 10'd0, 1, 10'd15, "R6");
    // R5: retrace in odd and even fields
    step(0, 0, 10'd0, 10'd1, 1, 10'd15, "R5");
    step(0, 0, 10'd0, 10'd0, 1, 10'd15, "R5");
    step(0, 0, 10'd0, 10'd1, 0, 10'd15, "R5");
    step(0, 0, 10'd0, 10'd0, 0, 10'd15, "R5");

    // R4: t1=5 -> line 10, t2=7 -> line 14; field of 10 lines (m1 = 9)
    step(1, 32'h0005_0007, 10'd10, 10'd1, 0, 10'd9, "R4");
    step(0, 0, 10'd10, 10'd0, 0, 10'd9, "R4");
    step(0, 0, 10'd11, 10'd1, 1, 10'd9, "R4");
    step(0, 0, 10'd11, 10'd0, 1, 10'd9, "R4");
    step(0, 0, 10'd14, 10'd1, 0, 10'd9, "R4");
    step(0, 0, 10'd14, 10'd0, 0, 10'd9, "R4");
    // boundary: m1 = 10 makes line 10 valid
    step(0, 0, 10'd10, 10'd1, 0, 10'd10, "R4");
    step(0, 0, 10'd10, 10'd0, 0, 10'd10, "R4");
    step(0, 0, 10'd10, 10'd1, 0, 10'd10, "R4");
    chk("R4 fires at last line", {31'd0, irq_scan1}, 32'd1);

    // R8: write in same cycle as line start uses old target
    step(1, 32'h0001_0000, 10'd2, 10'd1, 0, 10'd15, "R8");
    step(1, 32'h0003_0000, 10'd2, 10'd0, 0, 10'd15, "R8");
    step(0, 0, 10'd2, 10'd1, 0, 10'd15, "R8");
    chk("R8 old target fires", {31'd0, irq_scan1}, 32'd1);
    step(0, 0, 10'd2, 10'd0, 0, 10'd15, "R8");
    step(0, 0, 10'd6, 10'd1, 0, 10'd15, "R8");
    chk("R8 old target dropped", {31'd0, irq_scan1}, 32'd0);
    step(0, 0, 10'd6, 10'd0, 0, 10'd15, "R8");
    step(0, 0, 10'd6, 10'd1, 0, 10'd15, "R8");
    chk("R8 new target fires", {31'd0, irq_scan1}, 32'd1);

    // Random raster segments, R2 R3 R5 R7 under varied fields and lengths
    for (int s = 0; s < 30; s++) begin
      run_raster(500, 10'($urandom_range(4, 40)), $urandom_range(2, 6),
                 bit'($urandom_range(0, 1)), 25, "RND");
    end
    step(0, 0, 10'd0, 10'd1, 0, 10'd15, "END");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule